// File: doc/BRIEF.md
# DDR2 Command Issue and Bank Tracker

This block sits on the controller side of a DDR2 memory interface. It takes one user request per cycle and turns it into the registered chip-select, row strobe, column strobe, write-enable, bank and address pin pattern. The requests are mode-register load, row activate, column read, column write and bank precharge. Each bank has a small tracker. The tracker records whether a row is open, which row it is, and a down-counter for the time still needed before the next column access or the next activate.

A request that breaks a rule is not issued. The block raises a one-cycle error flag and drives a no-operation pattern in its place. It also drives a no-operation pattern when no request is presented, and it drives the deselected pattern while the enable input is low. Reads and writes may be issued before the row-to-column delay has fully passed, because the device registers them internally only after the additive latency. A short pipeline reports the cycle in which each posted column command becomes effective inside the device.

Top module: `ddr2_cmd_issuer`

## Requirements
- R1: After reset the pins show deselect (`cs_n`,`ras_n`,`cas_n`,`we_n` = 1111), `err` is 0 and no bank is open. With `en` high and no `req_valid`, the block drives NOP (0111) with `ba_o` and `addr_o` at zero.
- R2: While `en` is low the pins show deselect and `err` stays 0. Any presented request is dropped and bank state does not change.
- R3: An accepted command appears one clock after it is sampled, with `ba_o`/`addr_o` copied from the request. The `req_op` codes and their pin patterns (cs,ras,cas,we) are: 0 = mode load (0000), 1 = activate (0011), 2 = read (0101), 3 = write (0100), 4 = precharge (0010).
- R4: An accepted activate marks the bank open in `bank_open` and stores `req_addr` as that bank's row in `open_rows` (slice b is bits b*ADDR_W upward).
- R5: An activate to a bank that is open, or whose precharge time has not yet passed, is rejected.
- R6: A read or write to a bank with no open row is rejected.
- R7: A read or write is accepted from T_RCD−ADD_LAT cycles after the activate onward. An earlier one is rejected.
- R8: A precharge is accepted to an open bank, or to a closed bank whose counter has expired. It closes the bank, and the next activate to that bank is accepted no sooner than T_RP cycles later.
- R9: A read or write with address bit 10 set closes the bank at once. An activate to that bank is then rejected until ADD_LAT + BURST_LEN/2 + T_RP cycles have passed.
- R10: A mode load is accepted only when every bank is closed with its counter expired. It is otherwise rejected.
- R11: After an accepted mode load, every request is rejected for the next T_MRD−1 cycles.
- R12: Every accepted read or write produces a one-cycle `eff_valid` pulse ADD_LAT cycles after its pins appear. The pulse carries `eff_write` and `eff_bank` from that command.
- R13: A rejected request, including an unused op code (5 to 7), gives `err` = 1 for one cycle with NOP on the pins, and it leaves bank state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Low forces deselect and drops requests |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 3 | Request code (see R3) |
| req_bank | input | BA_W | Target bank, or mode register select |
| req_addr | input | ADDR_W | Row, column with bit 10 auto-close, or mode value |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank pins |
| addr_o | output | ADDR_W | Address pins |
| err | output | 1 | One-cycle pulse for a rejected request |
| bank_open | output | NUM_BANKS | Open-row flag per bank |
| open_rows | output | NUM_BANKS*ADDR_W | Stored row per bank |
| eff_valid | output | 1 | A posted column command becomes effective |
| eff_write | output | 1 | That command is a write |
| eff_bank | output | BA_W | That command's bank |

## Verification
The bench builds the block with T_RCD = 4 and ADD_LAT = 2. This makes the early-issue window real: a read one cycle after activate is refused, and the next cycle it is taken. With T_RP = 3, T_MRD = 2 and BURST_LEN = 4, the auto-close lockout lasts seven cycles. Repeated activate requests probe every cycle of that lockout, including the first cycle that accepts. The mode-load spacing of two leaves a single locked cycle, which is checked, followed by an accepted request.

// File: rtl/ddr2_cmd_pkg.sv
package ddr2_cmd_pkg;

  typedef enum logic [2:0] {
    OP_MRS = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4
  } op_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_DESEL = 4'b1111;
  localparam pins_t PINS_NOP   = 4'b0111;
  localparam pins_t PINS_ACT   = 4'b0011;
  localparam pins_t PINS_RD    = 4'b0101;
  localparam pins_t PINS_WR    = 4'b0100;
  localparam pins_t PINS_PRE   = 4'b0010;
  localparam pins_t PINS_MRS   = 4'b0000;

  localparam int AP_BIT = 10;

endpackage

// File: rtl/ddr2_bank_track.sv
module ddr2_bank_track #(
  parameter int ADDR_W    = 14,
  parameter int T_RCD     = 4,
  parameter int T_RP      = 3,
  parameter int ADD_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_i,
  input  logic              col_i,
  input  logic              ap_i,
  input  logic              pre_i,
  input  logic [ADDR_W-1:0] row_i,
  output logic              open_o,
  output logic [ADDR_W-1:0] row_o,
  output logic              act_ok_o,
  output logic              col_ok_o,
  output logic              pre_ok_o,
  output logic              idle_o
);
  localparam int AP_WAIT = ADD_LAT + BURST_LEN / 2 + T_RP;
  localparam int CNT_MAX = (AP_WAIT > T_RCD) ? AP_WAIT : T_RCD;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_AP  = CW'(AP_WAIT - 1);
  localparam logic [CW-1:0] AL_LIM = CW'(ADD_LAT);

  logic [CW-1:0] cnt_q;
  logic          open_q;
  logic [ADDR_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_i) begin
      cnt_q  <= LD_RCD;
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (col_i && ap_i) begin
      cnt_q  <= LD_AP;
      open_q <= 1'b0;
    end else if (pre_i) begin
      cnt_q  <= LD_RP;
      open_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign act_ok_o = !open_q && (cnt_q == '0);
  assign col_ok_o = open_q && (cnt_q <= AL_LIM);
  assign pre_ok_o = open_q || (cnt_q == '0);
  assign idle_o   = !open_q && (cnt_q == '0);
endmodule

// File: rtl/ddr2_posted_pipe.sv
module ddr2_posted_pipe #(
  parameter int DEPTH = 2,
  parameter int BA_W  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            v_i,
  input  logic            wr_i,
  input  logic [BA_W-1:0] bank_i,
  output logic            v_o,
  output logic            wr_o,
  output logic [BA_W-1:0] bank_o
);
  logic [DEPTH:0]  v_q;
  logic [DEPTH:0]  wr_q;
  logic [BA_W-1:0] bank_q [DEPTH+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q  <= '0;
      wr_q <= '0;
      for (int s = 0; s <= DEPTH; s++) bank_q[s] <= '0;
    end else begin
      v_q[0]    <= v_i;
      wr_q[0]   <= wr_i;
      bank_q[0] <= bank_i;
      for (int s = DEPTH; s > 0; s--) begin
        v_q[s]    <= v_q[s-1];
        wr_q[s]   <= wr_q[s-1];
        bank_q[s] <= bank_q[s-1];
      end
    end
  end

  assign v_o    = v_q[DEPTH];
  assign wr_o   = wr_q[DEPTH];
  assign bank_o = bank_q[DEPTH];
endmodule

// File: rtl/ddr2_cmd_issuer.sv
module ddr2_cmd_issuer
  import ddr2_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 14,
  parameter int T_RCD     = 4,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4,
  parameter int ADD_LAT   = 2,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        req_valid,
  input  logic [2:0]                  req_op,
  input  logic [BA_W-1:0]             req_bank,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        cs_n,
  output logic                        ras_n,
  output logic                        cas_n,
  output logic                        we_n,
  output logic [BA_W-1:0]             ba_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic                        err,
  output logic [NUM_BANKS-1:0]        bank_open,
  output logic [NUM_BANKS*ADDR_W-1:0] open_rows,
  output logic                        eff_valid,
  output logic                        eff_write,
  output logic [BA_W-1:0]             eff_bank
);
  localparam int MW = (T_MRD > 1) ? $clog2(T_MRD + 1) : 1;
  localparam logic [MW-1:0] LD_MRD = MW'(T_MRD - 1);

  op_e op;
  assign op = op_e'(req_op);

  logic [NUM_BANKS-1:0] act_sel, col_sel, pre_sel;
  logic [NUM_BANKS-1:0] act_ok, col_ok, pre_ok, idle;
  logic [MW-1:0]        mrd_q;
  logic                 legal, issue, reject, is_col;
  pins_t                pins_q;

  always_comb begin
    case (op)
      OP_MRS:       legal = &idle;
      OP_ACT:       legal = act_ok[req_bank];
      OP_RD, OP_WR: legal = col_ok[req_bank];
      OP_PRE:       legal = pre_ok[req_bank];
      default:      legal = 1'b0;
    endcase
    legal  = legal && (mrd_q == '0);
    issue  = en && req_valid && legal;
    reject = en && req_valid && !legal;
    is_col = (op == OP_RD) || (op == OP_WR);
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign act_sel[b] = issue && (op == OP_ACT) && (req_bank == BA_W'(b));
      assign col_sel[b] = issue && is_col && (req_bank == BA_W'(b));
      assign pre_sel[b] = issue && (op == OP_PRE) && (req_bank == BA_W'(b));

      ddr2_bank_track #(
        .ADDR_W(ADDR_W), .T_RCD(T_RCD), .T_RP(T_RP),
        .ADD_LAT(ADD_LAT), .BURST_LEN(BURST_LEN)
      ) u_bank (
        .clk(clk), .rst(rst),
        .act_i(act_sel[b]), .col_i(col_sel[b]),
        .ap_i(req_addr[AP_BIT]), .pre_i(pre_sel[b]),
        .row_i(req_addr),
        .open_o(bank_open[b]), .row_o(open_rows[b*ADDR_W +: ADDR_W]),
        .act_ok_o(act_ok[b]), .col_ok_o(col_ok[b]),
        .pre_ok_o(pre_ok[b]), .idle_o(idle[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mrd_q <= '0;
    end else if (issue && op == OP_MRS) begin
      mrd_q <= LD_MRD;
    end else if (mrd_q != '0) begin
      mrd_q <= mrd_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pins_q <= PINS_DESEL;
      ba_o   <= '0;
      addr_o <= '0;
      err    <= 1'b0;
    end else if (issue) begin
      case (op)
        OP_MRS:  pins_q <= PINS_MRS;
        OP_ACT:  pins_q <= PINS_ACT;
        OP_RD:   pins_q <= PINS_RD;
        OP_WR:   pins_q <= PINS_WR;
        default: pins_q <= PINS_PRE;
      endcase
      ba_o   <= req_bank;
      addr_o <= req_addr;
      err    <= 1'b0;
    end else begin
      pins_q <= PINS_NOP;
      ba_o   <= '0;
      addr_o <= '0;
      err    <= reject;
    end
  end

  assign cs_n  = pins_q.cs_n;
  assign ras_n = pins_q.ras_n;
  assign cas_n = pins_q.cas_n;
  assign we_n  = pins_q.we_n;

  ddr2_posted_pipe #(.DEPTH(ADD_LAT), .BA_W(BA_W)) u_pipe (
    .clk(clk), .rst(rst),
    .v_i(issue && is_col), .wr_i(op == OP_WR), .bank_i(req_bank),
    .v_o(eff_valid), .wr_o(eff_write), .bank_o(eff_bank)
  );
endmodule

// File: rtl/ddr2_cmd_issuer_chk.sv
module ddr2_cmd_issuer_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BA_W-1:0]      ba_o,
  input logic                 err,
  input logic [NUM_BANKS-1:0] bank_open
);
  logic [NUM_BANKS-1:0] prev_open;
  always_ff @(posedge clk) prev_open <= bank_open;

  logic act_pins, col_pins, mrs_pins;
  assign act_pins = !cs_n && !ras_n && cas_n && we_n;
  assign col_pins = !cs_n && ras_n && !cas_n;
  assign mrs_pins = !cs_n && !ras_n && !cas_n && !we_n;

  AST_DESELECT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cs_n && !err)); // R2
  AST_REJECT_IS_NOP: assert property (@(posedge clk) disable iff (rst)
    err |-> (!cs_n && ras_n && cas_n && we_n)); // R13
  AST_ACT_NEEDS_CLOSED: assert property (@(posedge clk) disable iff (rst)
    act_pins |-> !prev_open[ba_o]); // R5
  AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
    col_pins |-> prev_open[ba_o]); // R6
  AST_MODE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    mrs_pins |-> (prev_open == '0)); // R10
endmodule

bind ddr2_cmd_issuer ddr2_cmd_issuer_chk #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba_o(ba_o), .err(err), .bank_open(bank_open)
);

// File: tb/ddr2_cmd_issuer_bench.sv
module ddr2_cmd_issuer_bench;
  localparam int NB = 4, AW = 14, TRCD = 4, TRP = 3, TMRD = 2, BL = 4, AL = 2, BAW = 2;
  localparam int MRS = 0, ACT = 1, RD = 2, WR = 3, PRE = 4;

  logic clk = 0, rst = 1, en = 0, req_valid = 0;
  logic [2:0] req_op = '0;
  logic [BAW-1:0] req_bank = '0;
  logic [AW-1:0] req_addr = '0;
  logic cs_n, ras_n, cas_n, we_n, err, eff_valid, eff_write;
  logic [BAW-1:0] ba_o, eff_bank;
  logic [AW-1:0] addr_o;
  logic [NB-1:0] bank_open;
  logic [NB*AW-1:0] open_rows;

  ddr2_cmd_issuer #(.NUM_BANKS(NB), .ADDR_W(AW), .T_RCD(TRCD), .T_RP(TRP),
    .T_MRD(TMRD), .BURST_LEN(BL), .ADD_LAT(AL)) u_ddr2_cmd_issuer (
    .clk(clk), .rst(rst), .en(en), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_addr(req_addr), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba_o(ba_o), .addr_o(addr_o), .err(err),
    .bank_open(bank_open), .open_rows(open_rows), .eff_valid(eff_valid),
    .eff_write(eff_write), .eff_bank(eff_bank));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int m_open[NB], m_row[NB], m_col_from[NB], m_act_from[NB], m_mrd_from;
  int eff_t[$], eff_w[$], eff_b[$];

  task automatic step(input bit en_i, input bit v_i, input int op, input int bk,
                      input int ad, input string tag);
    bit legal, ev;
    int ew, eb;
    logic [3:0] e_pins, g_pins;
    logic [NB-1:0] e_open;
    int e_ba, e_addr;
    bit e_err, bad;
    en = en_i; req_valid = v_i; req_op = op[2:0];
    req_bank = bk[BAW-1:0]; req_addr = ad[AW-1:0];
    @(posedge clk);
    cyc++;
    e_err = 0; e_ba = 0; e_addr = 0;
    if (!en_i) e_pins = 4'b1111;
    else if (!v_i) e_pins = 4'b0111;
    else begin
      legal = (cyc >= m_mrd_from);
      case (op)
        MRS: for (int b = 0; b < NB; b++) if (m_open[b] != 0 || cyc < m_act_from[b]) legal = 0;
        ACT: if (m_open[bk] != 0 || cyc < m_act_from[bk]) legal = 0;
        RD, WR: if (m_open[bk] == 0 || cyc < m_col_from[bk]) legal = 0;
        PRE: if (m_open[bk] == 0 && cyc < m_act_from[bk]) legal = 0;
        default: legal = 0;
      endcase
      if (!legal) begin
        e_pins = 4'b0111; e_err = 1;
      end else begin
        e_ba = bk; e_addr = ad;
        case (op)
          MRS: begin e_pins = 4'b0000; m_mrd_from = cyc + TMRD; end
          ACT: begin e_pins = 4'b0011; m_open[bk] = 1; m_row[bk] = ad; m_col_from[bk] = cyc + TRCD - AL; end
          RD, WR: begin
            e_pins = (op == WR) ? 4'b0100 : 4'b0101;
            eff_t.push_back(cyc + AL); eff_w.push_back(op == WR); eff_b.push_back(bk);
            if (ad[10]) begin m_open[bk] = 0; m_act_from[bk] = cyc + AL + BL / 2 + TRP; end
          end
          default: begin e_pins = 4'b0010; m_open[bk] = 0; m_act_from[bk] = cyc + TRP; end
        endcase
      end
    end
    ev = 0; ew = 0; eb = 0;
    if (eff_t.size() > 0 && eff_t[0] == cyc) begin
      ev = 1; ew = eff_w.pop_front(); eb = eff_b.pop_front(); void'(eff_t.pop_front());
    end
    for (int b = 0; b < NB; b++) e_open[b] = (m_open[b] != 0);
    @(negedge clk);
    g_pins = {cs_n, ras_n, cas_n, we_n};
    bad = (g_pins != e_pins) || (ba_o != e_ba[BAW-1:0]) || (addr_o != e_addr[AW-1:0]) ||
          (err != e_err) || (eff_valid != ev) || (bank_open != e_open) ||
          (ev && (eff_write != ew[0] || eff_bank != eb[BAW-1:0]));
    for (int b = 0; b < NB; b++)
      if (m_open[b] != 0 && open_rows[b*AW +: AW] != m_row[b][AW-1:0]) bad = 1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s cyc %0d: got pins=%b ba=%0d addr=%h err=%b open=%b eff=%b/%b/%0d, expected pins=%b ba=%0d addr=%h err=%b open=%b eff=%b/%0d/%0d",
               tag, cyc, g_pins, ba_o, addr_o, err, bank_open, eff_valid, eff_write, eff_bank,
               e_pins, e_ba, e_addr[AW-1:0], e_err, e_open, ev, ew, eb);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; m_col_from[b] = 0; m_act_from[b] = 0; end
    m_mrd_from = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({cs_n, ras_n, cas_n, we_n} != 4'b1111 || err || bank_open != '0 || eff_valid) begin
      errors++;
      $display("FAIL R1 reset: got pins=%b err=%b open=%b eff=%b, expected 1111 0 0000 0",
               {cs_n, ras_n, cas_n, we_n}, err, bank_open, eff_valid);
    end
    rst = 0;
    step(1, 0, 0, 0, 0, "R1");
    step(0, 1, ACT, 0, 5, "R2");
    step(1, 1, ACT, 0, 'h123, "R4");
    step(1, 1, RD, 0, 8, "R7");
    step(1, 1, RD, 0, 8, "R7");
    step(1, 1, ACT, 0, 7, "R5");
    step(1, 0, 0, 0, 0, "R12");
    step(1, 1, RD, 1, 0, "R6");
    step(1, 1, WR, 0, 'h10, "R3");
    step(1, 1, MRS, 0, 0, "R10");
    step(1, 1, ACT, 2, 'h3ff, "R4");
    step(0, 1, PRE, 2, 0, "R2");
    step(1, 1, PRE, 0, 0, "R8");
    repeat (5) step(1, 1, ACT, 0, 9, "R8");
    repeat (3) step(1, 0, 0, 0, 0, "R12");
    step(1, 1, WR, 0, (1 << 10) | 4, "R9");
    step(1, 1, RD, 0, 4, "R9");
    repeat (8) step(1, 1, ACT, 0, 2, "R9");
    step(1, 1, PRE, 0, 0, "R8");
    step(1, 1, PRE, 2, 0, "R8");
    step(1, 1, PRE, 1, 0, "R8");
    repeat (3) step(1, 0, 0, 0, 0, "R1");
    step(1, 1, MRS, 1, 'h42, "R10");
    step(1, 1, ACT, 1, 3, "R11");
    step(1, 1, ACT, 1, 3, "R11");
    step(1, 1, 5, 0, 0, "R13");
    step(1, 1, 7, 3, 0, "R13");
    repeat (4) step(1, 0, 0, 0, 0, "R12");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule